// File: doc/BRIEF.md
# Serial Audio Port Control and Status Register

This block is the control and status word for one direction of a serial audio port. It holds the transfer enable, the DMA request enable, a software reset, a FIFO flush command and five interrupt enables, each with a matching event flag. The serial engine and the FIFO report their events to the block as pulses or levels. The block turns those events into a level interrupt and a DMA request, and it reports whether the direction is still running.

Software uses a plain 32-bit write port and a combinational read port. Three of the flags are sticky. Software clears one of them by writing a one to its bit. The other two flags follow the FIFO state directly. When software turns the transfer enable off, the direction keeps running until the serial engine marks the end of a frame. Software can poll the enable bit to learn when the stop has completed.

Top module: `audio_port_csr`

## Requirements
- R1: After reset, `rd_data` reads zero when `fifo_warn` and `fifo_req` are low, and `irq`, `dma_req`, `fifo_flush` and `xfer_active` are low.
- R2: Register layout: bit 0 is the DMA request enable. Bits 8..12 are the interrupt enables for word start, sync error, FIFO error, FIFO warning and FIFO request, in that order. Bits 16..20 are the flags in the same order, so each flag sits 8 bits above its enable. Bit 24 is the software reset, bit 25 is the FIFO flush and bit 31 is the transfer enable. All other bits read zero. Every field except the flags and the flush is read/write. A pulse on `ev_word_start`, `ev_sync_err` or `ev_fifo_err` sets the matching sticky flag from the next cycle on.
- R3: Writing one to a sticky flag bit (16, 17 or 18) clears that flag. Writing zero to it leaves the flag unchanged.
- R4: If an event and a write of one to the same flag fall in the same cycle, the flag is set afterwards.
- R5: Flag bits 19 and 20 show `fifo_warn` and `fifo_req` live. Writes to these bits have no effect.
- R6: A write with bit 25 set gives a one-cycle `fifo_flush` pulse in the following cycle. Bit 25 always reads zero.
- R7: While the software reset bit is set, the sticky flags are held at zero and events are ignored. The live flags read zero, the transfer enable is forced to zero, and `irq` and `dma_req` stay low. The enables and the DMA enable keep the values written to them.
- R8: Writing one to bit 31 makes bit 31 and `xfer_active` high from the next cycle on. Writing zero leaves both high until a cycle in which `frame_end` is high, counting the cycle of the write itself. Both drop in the cycle after that.
- R9: `dma_req` equals DMA enable AND `fifo_req`, outside software reset.
- R10: `irq` is high exactly when some flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value |
| ev_word_start | input | 1 | Word start event pulse |
| ev_sync_err | input | 1 | Frame sync error event pulse |
| ev_fifo_err | input | 1 | FIFO underrun/overflow event pulse |
| fifo_warn | input | 1 | FIFO empty (transmit) or full (receive) level |
| fifo_req | input | 1 | FIFO watermark reached level |
| frame_end | input | 1 | Current frame ends in this cycle |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | DMA request |
| fifo_flush | output | 1 | FIFO pointer flush pulse |
| xfer_active | output | 1 | Live transfer enable state |

## Verification
Two pairs of functions can fall in the same cycle. A new event can arrive together with a write-one clear of its own flag, and a write that turns the enable off can arrive together with the end-of-frame marker. Directed steps force both coincidences. The random phase drives events, clearing writes and `frame_end` independently, so both overlaps also occur many times at random. Each result is judged against a bench model that gives the event priority over the clear and counts the end-of-frame marker in the cycle of the stop write.

// File: rtl/audio_port_csr.sv
module audio_port_csr #(
  parameter int DW       = 32,
  parameter int N_EV     = 5,
  parameter int N_STICKY = 3,
  parameter int DMA_BIT  = 0,
  parameter int IE_LSB   = 8,
  parameter int FLAG_OFS = 8,
  parameter int SRST_BIT = 24,
  parameter int FRST_BIT = 25,
  parameter int EN_BIT   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ev_word_start,
  input  logic          ev_sync_err,
  input  logic          ev_fifo_err,
  input  logic          fifo_warn,
  input  logic          fifo_req,
  input  logic          frame_end,
  output logic          irq,
  output logic          dma_req,
  output logic          fifo_flush,
  output logic          xfer_active
);
  localparam int FLAG_LSB = IE_LSB + FLAG_OFS;

  logic [N_EV-1:0]     ie;
  logic [N_STICKY-1:0] sticky;
  logic                dma_en, srst, en_req, en_act;

  logic [N_STICKY-1:0] ev_in, w1c;
  logic [N_EV-1:0]     flags;
  logic                srst_nxt, en_req_nxt;

  assign ev_in      = {ev_fifo_err, ev_sync_err, ev_word_start};
  assign w1c        = wr_en ? wr_data[FLAG_LSB +: N_STICKY] : '0;
  assign srst_nxt   = wr_en ? wr_data[SRST_BIT] : srst;
  assign en_req_nxt = !srst_nxt && (wr_en ? wr_data[EN_BIT] : en_req);
  assign flags      = {fifo_req & ~srst, fifo_warn & ~srst, sticky};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie         <= '0;
      dma_en     <= 1'b0;
      srst       <= 1'b0;
      sticky     <= '0;
      en_req     <= 1'b0;
      en_act     <= 1'b0;
      fifo_flush <= 1'b0;
    end else begin
      if (wr_en) begin
        ie     <= wr_data[IE_LSB +: N_EV];
        dma_en <= wr_data[DMA_BIT];
      end
      srst       <= srst_nxt;
      fifo_flush <= wr_en && wr_data[FRST_BIT];
      en_req     <= en_req_nxt;
      if (srst_nxt) begin
        sticky <= '0;
        en_act <= 1'b0;
      end else begin
        sticky <= (sticky & ~w1c) | ev_in;
        en_act <= en_req_nxt || (en_act && !frame_end);
      end
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[DMA_BIT]            = dma_en;
    rd_data[IE_LSB +: N_EV]     = ie;
    rd_data[FLAG_LSB +: N_EV]   = flags;
    rd_data[SRST_BIT]           = srst;
    rd_data[EN_BIT]             = en_act;
  end

  assign irq         = |(flags & ie);
  assign dma_req     = dma_en && fifo_req && !srst;
  assign xfer_active = en_act;

  p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sync_err && !srst_nxt) |=> rd_data[FLAG_LSB+1]);

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG_LSB+2] && !ev_fifo_err) |=> !rd_data[FLAG_LSB+2]);

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG_LSB] && !wr_data[SRST_BIT] && ev_word_start) |=> rd_data[FLAG_LSB]);

  p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !wr_en) |=> !fifo_flush);

  p_srst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (!irq && !dma_req && !xfer_active));

  p_stop_waits_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !frame_end && !srst_nxt) |=> xfer_active);

  p_dma_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> fifo_req);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rd_data[FLAG_LSB +: N_EV] & rd_data[IE_LSB +: N_EV]) != '0));
endmodule

// File: tb/test_audio_port_csr.sv
module test_audio_port_csr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        ev_ws = 1'b0, ev_se = 1'b0, ev_fe = 1'b0;
  logic        fwarn = 1'b0, freq = 1'b0, fend = 1'b0;
  logic [31:0] rd_data;
  logic        irq, dma_req, fifo_flush, xfer_active;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [4:0] m_ie;
  logic [2:0] m_sticky;
  logic       m_dma, m_srst, m_en_req, m_en_act, m_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_port_csr i_audio_port_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_word_start(ev_ws), .ev_sync_err(ev_se), .ev_fifo_err(ev_fe),
    .fifo_warn(fwarn), .fifo_req(freq), .frame_end(fend),
    .irq(irq), .dma_req(dma_req), .fifo_flush(fifo_flush), .xfer_active(xfer_active)
  );

  function automatic logic [4:0] exp_flags();
    return {freq & ~m_srst, fwarn & ~m_srst, m_sticky};
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[0]     = m_dma;
    r[12:8]  = m_ie;
    r[20:16] = exp_flags();
    r[24]    = m_srst;
    r[31]    = m_en_act;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clock();
    logic       s_n, r_n;
    logic [2:0] clr;
    s_n = wr_en ? wr_data[24] : m_srst;
    r_n = !s_n && (wr_en ? wr_data[31] : m_en_req);
    clr = wr_en ? wr_data[18:16] : 3'b000;
    if (wr_en) begin
      m_ie  = wr_data[12:8];
      m_dma = wr_data[0];
    end
    m_flush = wr_en && wr_data[25];
    if (s_n) begin
      m_sticky = '0;
      m_en_act = 1'b0;
    end else begin
      m_sticky = (m_sticky & ~clr) | {ev_fe, ev_se, ev_ws};
      m_en_act = r_n || (m_en_act && !fend);
    end
    m_srst   = s_n;
    m_en_req = r_n;
  endtask

  task automatic compare_all();
    check("R2 rd_data", rd_data, exp_rd());
    check("R10 irq", {31'd0, irq}, {31'd0, |(exp_flags() & m_ie)});
    check("R9 dma_req", {31'd0, dma_req}, {31'd0, m_dma & freq & ~m_srst});
    check("R6 fifo_flush", {31'd0, fifo_flush}, {31'd0, m_flush});
    check("R8 xfer_active", {31'd0, xfer_active}, {31'd0, m_en_act});
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [2:0] ev,
                      input logic warn, input logic rq, input logic fe);
    @(negedge clk);
    wr_en = w; wr_data = d; {ev_fe, ev_se, ev_ws} = ev;
    fwarn = warn; freq = rq; fend = fe;
    #1;
    compare_all();
    @(posedge clk);
    model_clock();
    #(CLK_PERIOD/4);
  endtask

  task automatic idle(); step(1'b0, 32'd0, 3'b000, fwarn, freq, 1'b0); endtask

  initial begin
    m_ie = '0; m_sticky = '0; m_dma = 0; m_srst = 0; m_en_req = 0; m_en_act = 0; m_flush = 0;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD*3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset rd_data", rd_data, 32'd0);
    check("R1 reset outputs", {28'd0, irq, dma_req, fifo_flush, xfer_active}, 32'd0);

    step(1'b0, 0, 3'b010, 0, 0, 0);
    check("R2 sync error flag", {31'd0, rd_data[17]}, 32'd1);
    step(1'b1, 32'h0000_0000, 3'b000, 0, 0, 0);
    check("R3 write zero keeps flag", {31'd0, rd_data[17]}, 32'd1);
    step(1'b1, 32'h0002_0000, 3'b000, 0, 0, 0);
    check("R3 write one clears flag", {31'd0, rd_data[17]}, 32'd0);

    step(1'b0, 0, 3'b001, 0, 0, 0);
    step(1'b1, 32'h0001_0000, 3'b001, 0, 0, 0);
    check("R4 event beats clear", {31'd0, rd_data[16]}, 32'd1);
    step(1'b1, 32'h0001_0000, 3'b000, 0, 0, 0);

    step(1'b1, 32'h0018_0000, 3'b000, 0, 0, 0);
    check("R5 live flags not writable", {30'd0, rd_data[20:19]}, 32'd0);
    step(1'b0, 0, 3'b000, 1, 0, 0);
    check("R5 warn flag live", {31'd0, rd_data[19]}, 32'd1);

    step(1'b1, 32'h0200_1001, 3'b000, 1, 1, 0);
    check("R6 flush pulse", {31'd0, fifo_flush}, 32'd1);
    check("R6 flush reads zero", {31'd0, rd_data[25]}, 32'd0);
    check("R9 dma request", {31'd0, dma_req}, 32'd1);
    check("R10 irq from request", {31'd0, irq}, 32'd1);
    idle();
    check("R6 flush one cycle", {31'd0, fifo_flush}, 32'd0);

    step(1'b1, 32'h8000_0000, 3'b000, 0, 0, 0);
    check("R8 enable on", {31'd0, rd_data[31]}, 32'd1);
    step(1'b1, 32'h0000_0000, 3'b000, 0, 0, 0);
    idle(); idle();
    check("R8 enable held until frame end", {31'd0, xfer_active}, 32'd1);
    step(1'b0, 0, 3'b000, 0, 0, 1);
    check("R8 enable drops after frame end", {31'd0, xfer_active}, 32'd0);
    step(1'b1, 32'h8000_0000, 3'b000, 0, 0, 0);
    step(1'b1, 32'h0000_0000, 3'b000, 0, 0, 1);
    check("R8 stop with frame end same cycle", {31'd0, xfer_active}, 32'd0);

    step(1'b1, 32'h8100_1f01, 3'b111, 1, 1, 0);
    step(1'b0, 0, 3'b111, 1, 1, 0);
    check("R7 flags held clear", {27'd0, rd_data[20:16]}, 32'd0);
    check("R7 quiet outputs", {29'd0, irq, dma_req, xfer_active}, 32'd0);
    check("R7 config kept", {26'd0, rd_data[12:8], rd_data[0]}, 32'h3f);
    step(1'b1, 32'h0000_1f01, 3'b000, 0, 0, 0);
    check("R7 released", {31'd0, rd_data[24]}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [31:0] d;
      w = ($urandom % 3) == 0;
      d = $urandom;
      if (($urandom % 6) != 0) d[24] = 1'b0;
      step(w, d, 3'($urandom % 8 == 0 ? $urandom : 0), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule